// File: doc/BRIEF.md
# Write-Through Data Cache with Store FIFO

This block is a direct-mapped data cache placed between a processor load/store port and a single memory request channel. A load that finds its line resident is answered combinationally in the cycle it is presented. A load that misses holds the processor. The cache issues one block-aligned read, takes four words back from memory, writes them into the line, and hands the requested word to the processor in the cycle the last word lands.

Stores never wait on memory directly. Each accepted store updates the cache when the line is resident and is also queued in a small FIFO that writes to memory whenever the channel is free. The parameter `WRITE_ALLOC` chooses what a store miss does. When it is 1, the block is fetched first and the store then completes as a hit. When it is 0, the store goes only to the FIFO and the array is left alone. A load miss whose block still has a queued store keeps the FIFO draining until no entry of that block is left. Only then does it read memory, so it never fetches stale data.

The controller is a four-state machine:
- `ST_LOOKUP`: serve hits and accept stores.
- `ST_DRAIN`: the FIFO empties entries of the missing block.
- `ST_FILL_REQ`: the read request is held until memory accepts it.
- `ST_FILL_BEAT`: four response words are collected.

Its transitions are:
- LOOKUP→DRAIN on a fill-needing miss whose block is queued.
- LOOKUP→FILL_REQ on a fill-needing miss with no such entry.
- DRAIN→FILL_REQ once the block has left the FIFO.
- FILL_REQ→FILL_BEAT on request acceptance.
- FILL_BEAT→LOOKUP on the fourth word.

Top module: `wt_cache`

## Requirements
- R1: Addresses are byte addresses split as bits [3:2] word select, bits [IDX_W+3:4] line index, and the remaining upper bits tag. A load to a resident line returns that word with `cpu_stall` low in the same cycle.
- R2: A load miss raises `cpu_stall` and issues exactly one read request (`mem_req_we`=0) whose address is the block address (low four bits zero). The request is held until `mem_req_ready`.
- R3: The fill returns four words in order (word 0 first), one per `mem_rsp_valid` cycle. The requested word appears on `cpu_rdata` with `cpu_stall` low in the fourth beat cycle, and later loads to that block hit without a memory read.
- R4: Every accepted store (`cpu_req`, `cpu_we`, `cpu_stall` low) enters the FIFO, and stores reach memory in acceptance order. After draining, memory holds the last value stored to each word.
- R5: A store to a resident line updates the cached word and is accepted in its first cycle when the FIFO has room.
- R6: With `WRITE_ALLOC`=1, a store miss triggers one block read and then writes the word, so later loads of that block hit with the stored value.
- R7: With `WRITE_ALLOC`=0, a store miss causes no block read and no stall when the FIFO has room. It leaves the array unchanged, so a following load of that block misses.
- R8: While the FIFO is full, a store is stalled until an entry leaves. No store is lost.
- R9: No block read is issued while the FIFO holds a store to the same block. The load then returns the stored value.
- R10: After reset all lines are invalid, no memory request is presented, and `cpu_stall` is low while no access is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until not stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data |
| cpu_stall | output | 1 | Access not completed this cycle |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = word write, 0 = block read |
| mem_req_addr | output | AW | Byte address of request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Fill word present |
| mem_rsp_data | input | 32 | Fill word |

## Verification
Directed sequences cover several cases: a cold load against a repeat load of the same block, which separates the miss path from the hit path; a store hit against a store miss under each allocation setting, which shows whether the array was touched; and a FIFO held full by a stalled memory, which shows both the store stall and the read-after-write guard. A random stream then mixes loads and stores over a few indices with four tags each, forcing repeated evictions while memory readiness varies cycle to cycle. Its loads are compared against a bench shadow of memory, and at the end the final memory image is compared against that shadow as well.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int WORD_W  = 32;
    localparam int WSEL_W  = 2;
    localparam int BOFF_W  = WSEL_W + 2;
    localparam int BLK_WORDS = 1 << WSEL_W;

    typedef enum logic [1:0] {
        ST_LOOKUP,
        ST_DRAIN,
        ST_FILL_REQ,
        ST_FILL_BEAT
    } wtc_state_e;
endpackage

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int BLK_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [AW-1:0]    push_addr,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic             empty,
    output logic             full,
    output logic [AW-1:0]    head_addr,
    output logic [DW-1:0]    head_data,
    input  logic [BLK_W-1:0] query_blk,
    output logic             blk_hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int BLK_LSB = AW - BLK_W;

    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [DEPTH-1:0] occ_q, occ_d, match;
    logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (occ_q == '0);
    assign full      = &occ_q;
    assign head_addr = addr_q[rd_ptr_q];
    assign head_data = data_q[rd_ptr_q];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = occ_q[g] && (addr_q[g][AW-1:BLK_LSB] == query_blk);
        end
    endgenerate
    assign blk_hit = |match;

    always_comb begin
        occ_d = occ_q;
        if (pop)  occ_d[rd_ptr_q] = 1'b0;
        if (push) occ_d[wr_ptr_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q    <= '0;
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
        end else begin
            occ_q <= occ_d;
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            if (push) wr_ptr_q <= bump(wr_ptr_q);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr_q] <= push_addr;
            data_q[wr_ptr_q] <= push_data;
        end
    end
endmodule

// File: rtl/wtc_array.sv
module wtc_array
    import wtc_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [AW-IDX_W-BOFF_W-1:0] lk_tag,
    input  logic [WSEL_W-1:0] lk_wsel,
    output logic              lk_hit,
    output logic [WORD_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              tag_wr
);
    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = AW - IDX_W - BOFF_W;

    logic [WORD_W-1:0] data_q [LINES][BLK_WORDS];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINES-1:0]  vld_q;

    assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_data = data_q[lk_idx][lk_wsel];

    always_ff @(posedge clk) begin
        if (wr_en) data_q[lk_idx][wr_wsel] <= wr_data;
        if (tag_wr) tag_q[lk_idx] <= lk_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      vld_q <= '0;
        else if (tag_wr) vld_q[lk_idx] <= 1'b1;
    end
endmodule

// File: rtl/wt_cache.sv
module wt_cache
    import wtc_pkg::*;
#(
    parameter int AW          = 16,
    parameter int IDX_W       = 4,
    parameter int WB_DEPTH    = 4,
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [AW-1:0]     mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data
);
    localparam int TAG_W = AW - IDX_W - BOFF_W;
    localparam int BLK_W = AW - BOFF_W;

    wtc_state_e state_q, state_d;
    logic [WSEL_W-1:0] beat_q;
    logic [WORD_W-1:0] held_q;

    logic [WSEL_W-1:0] wsel;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [BLK_W-1:0]  blk;
    logic              unused_byte_bits;

    logic              hit, need_fill, last_beat;
    logic [WORD_W-1:0] arr_rdata, arr_wr_data;
    logic              arr_wr_en, tag_wr;
    logic [WSEL_W-1:0] arr_wr_wsel;

    logic              wb_push, wb_pop, wb_empty, wb_full, wb_blk_hit, wb_drive;
    logic [AW-1:0]     wb_head_addr;
    logic [WORD_W-1:0] wb_head_data;

    assign wsel = cpu_addr[BOFF_W-1:2];
    assign idx  = cpu_addr[BOFF_W +: IDX_W];
    assign tag  = cpu_addr[AW-1 -: TAG_W];
    assign blk  = cpu_addr[AW-1:BOFF_W];
    assign unused_byte_bits = ^cpu_addr[1:0];

    wtc_array #(.AW(AW), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_idx  (idx),
        .lk_tag  (tag),
        .lk_wsel (wsel),
        .lk_hit  (hit),
        .lk_data (arr_rdata),
        .wr_en   (arr_wr_en),
        .wr_wsel (arr_wr_wsel),
        .wr_data (arr_wr_data),
        .tag_wr  (tag_wr)
    );

    wtc_wbuf #(.AW(AW), .DW(WORD_W), .DEPTH(WB_DEPTH), .BLK_W(BLK_W)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wb_push),
        .push_addr (cpu_addr),
        .push_data (cpu_wdata),
        .pop       (wb_pop),
        .empty     (wb_empty),
        .full      (wb_full),
        .head_addr (wb_head_addr),
        .head_data (wb_head_data),
        .query_blk (blk),
        .blk_hit   (wb_blk_hit)
    );

    assign need_fill = cpu_req && !hit && (!cpu_we || WRITE_ALLOC);
    assign last_beat = (state_q == ST_FILL_BEAT) && mem_rsp_valid && (beat_q == '1);
    assign wb_drive  = !wb_empty && (state_q != ST_FILL_REQ);
    assign wb_pop    = wb_drive && mem_req_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            held_q <= '0;
        end else if (state_q == ST_FILL_REQ) begin
            beat_q <= '0;
        end else if (state_q == ST_FILL_BEAT && mem_rsp_valid) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == wsel) held_q <= mem_rsp_data;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP:    if (need_fill) state_d = wb_blk_hit ? ST_DRAIN : ST_FILL_REQ;
            ST_DRAIN:     if (!wb_blk_hit) state_d = ST_FILL_REQ;
            ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_BEAT;
            ST_FILL_BEAT: if (last_beat) state_d = ST_LOOKUP;
            default:      state_d = ST_LOOKUP;
        endcase
    end

    // outputs towards processor and array
    always_comb begin
        cpu_stall   = 1'b1;
        cpu_rdata   = arr_rdata;
        wb_push     = 1'b0;
        arr_wr_en   = 1'b0;
        arr_wr_wsel = wsel;
        arr_wr_data = cpu_wdata;
        tag_wr      = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                cpu_stall = cpu_req && (cpu_we ? (wb_full || need_fill) : !hit);
                wb_push   = cpu_req && cpu_we && !cpu_stall;
                arr_wr_en = wb_push && hit;
            end
            ST_FILL_BEAT: begin
                arr_wr_en   = mem_rsp_valid;
                arr_wr_wsel = beat_q;
                arr_wr_data = mem_rsp_data;
                tag_wr      = last_beat;
                if (last_beat && !cpu_we) begin
                    cpu_stall = 1'b0;
                    cpu_rdata = (wsel == beat_q) ? mem_rsp_data : held_q;
                end
            end
            default: ;
        endcase
    end

    // memory request channel: fill read wins, otherwise the FIFO head
    always_comb begin
        mem_req_valid = (state_q == ST_FILL_REQ) || wb_drive;
        if (state_q == ST_FILL_REQ) begin
            mem_req_we    = 1'b0;
            mem_req_addr  = {blk, {BOFF_W{1'b0}}};
            mem_req_wdata = '0;
        end else begin
            mem_req_we    = 1'b1;
            mem_req_addr  = wb_head_addr;
            mem_req_wdata = wb_head_data;
        end
    end
endmodule

// File: rtl/wt_cache_checker.sv
module wt_cache_checker
    import wtc_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic          cpu_stall,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          mem_req_we,
    input logic [AW-1:0] mem_req_addr,
    input logic          hit,
    input logic          in_lookup,
    input logic          wb_full,
    input logic          wb_blk_hit
);
    AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && hit && in_lookup) |-> !cpu_stall); // R1

    AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we) |-> (mem_req_addr[BOFF_W-1:0] == '0)); // R2

    AST_FILL_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we && !mem_req_ready) |=> (mem_req_valid && !mem_req_we)); // R2

    AST_NO_STALE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we) |-> !wb_blk_hit); // R9

    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && wb_full) |-> cpu_stall); // R8
endmodule

bind wt_cache wt_cache_checker #(.AW(AW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .cpu_stall     (cpu_stall),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .hit           (hit),
    .in_lookup     (state_q == wtc_pkg::ST_LOOKUP),
    .wb_full       (wb_full),
    .wb_blk_hit    (wb_blk_hit)
);

// File: tb/wt_cache_tb_top.sv
module wt_cache_tb_core #(
    parameter bit WA         = 1'b1,
    parameter int CLK_PERIOD = 10,
    parameter int SEED       = 1
);
    localparam int AW = 10;
    localparam int IDX_W = 4;
    localparam int WB_DEPTH = 4;
    localparam int NWORDS = 1 << (AW - 2);

    logic clk = 1'b0;
    logic rst_n;
    logic cpu_req, cpu_we, cpu_stall;
    logic [AW-1:0] cpu_addr;
    logic [31:0] cpu_wdata, cpu_rdata;
    logic mem_req_valid, mem_req_we, mem_rsp_valid;
    logic rdy;
    logic [AW-1:0] mem_req_addr;
    logic [31:0] mem_req_wdata, mem_rsp_data;

    bit hold_ready;
    bit done;
    int checks, fails;
    int rd_reqs;
    logic [AW-1:0] last_rd_addr;
    logic [31:0] ref_mem [NWORDS];
    logic [31:0] mmem [NWORDS];
    logic [NWORDS-1:0] mwr;
    logic [AW-3:0] rd_base;
    int rsp_left, rsp_delay;

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_cache #(.AW(AW), .IDX_W(IDX_W), .WB_DEPTH(WB_DEPTH), .WRITE_ALLOC(WA)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req_valid(mem_req_valid), .mem_req_ready(rdy), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] init_word(input int i);
        return 32'hC0DE0000 ^ (32'(i) * 32'h00010203);
    endfunction

    function automatic logic [31:0] mem_val(input int i);
        return mwr[i] ? mmem[i] : init_word(i);
    endfunction

    // memory model
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mwr <= '0; rdy <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
            rsp_left <= 0; rsp_delay <= 0; rd_reqs <= 0; rd_base <= '0; last_rd_addr <= '0;
        end else begin
            rdy <= !hold_ready && ($urandom_range(3) != 0);
            mem_rsp_valid <= 1'b0;
            if (rsp_left != 0) begin
                if (rsp_delay != 0) rsp_delay <= rsp_delay - 1;
                else begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem_val(int'(rd_base) + 4 - rsp_left);
                    rsp_left      <= rsp_left - 1;
                end
            end
            if (mem_req_valid && rdy) begin
                if (mem_req_we) begin
                    mmem[mem_req_addr[AW-1:2]] <= mem_req_wdata;
                    mwr[mem_req_addr[AW-1:2]]  <= 1'b1;
                end else begin
                    rd_base <= mem_req_addr[AW-1:2];
                    rsp_left <= 4; rsp_delay <= 1;
                    rd_reqs <= rd_reqs + 1;
                    last_rd_addr <= mem_req_addr;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s (WA=%0d): actual=%h expected=%h", rq, what, WA, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cyc = 0;
        forever begin
            #1; cyc++;
            if (!cpu_stall) break;
            @(negedge clk);
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0;
        if (we) ref_mem[a[AW-1:2]] = d;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] rd;
    int cyc, r0;
    logic [AW-1:0] a;

    initial begin
        for (int i = 0; i < NWORDS; i++) ref_mem[i] = init_word(i);
        cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
        hold_ready = 0; done = 0; checks = 0; fails = 0;
        void'($urandom(SEED));
        rst_n = 0;
        idle(3);
        rst_n = 1;
        @(negedge clk); #1;
        chk(!cpu_stall && !mem_req_valid, "R10", "idle outputs after reset",
            {30'd0, cpu_stall, mem_req_valid}, 0);

        // cold load
        r0 = rd_reqs;
        access(0, 10'h040, 0, rd, cyc);
        chk(cyc > 1, "R10", "cold load stalls (lines invalid)", cyc, 2);
        chk(rd_reqs == r0 + 1, "R2", "one block read", rd_reqs, r0 + 1);
        chk(last_rd_addr == 10'h040, "R2", "read block aligned", 32'(last_rd_addr), 32'h040);
        chk(rd == ref_mem[10'h040 >> 2], "R3", "fill word to cpu", rd, ref_mem[10'h040 >> 2]);

        access(0, 10'h04C, 0, rd, cyc);
        chk(cyc == 1, "R1", "hit answered in first cycle", cyc, 1);
        chk(rd_reqs == r0 + 1, "R3", "block hit needs no read", rd_reqs, r0 + 1);
        chk(rd == ref_mem[10'h04C >> 2], "R1", "hit data", rd, ref_mem[10'h04C >> 2]);

        // store hit
        access(1, 10'h048, 32'hDEAD0001, rd, cyc);
        chk(cyc == 1, "R5", "store hit accepted at once", cyc, 1);
        access(0, 10'h048, 0, rd, cyc);
        chk(cyc == 1 && rd == 32'hDEAD0001, "R5", "store hit updates line", rd, 32'hDEAD0001);

        // store miss
        r0 = rd_reqs;
        access(1, 10'h180, 32'hBEEF0002, rd, cyc);
        if (WA) begin
            chk(rd_reqs == r0 + 1, "R6", "allocate fetches block", rd_reqs, r0 + 1);
            r0 = rd_reqs;
            access(0, 10'h184, 0, rd, cyc);
            chk(cyc == 1 && rd_reqs == r0, "R6", "allocated block hits", cyc, 1);
            access(0, 10'h180, 0, rd, cyc);
            chk(rd == 32'hBEEF0002, "R6", "allocated word value", rd, 32'hBEEF0002);
        end else begin
            chk(rd_reqs == r0 && cyc == 1, "R7", "no fetch, no stall", rd_reqs, r0);
            access(0, 10'h184, 0, rd, cyc);
            chk(cyc > 1 && rd_reqs == r0 + 1, "R7", "line unchanged so load misses", rd_reqs, r0 + 1);
            access(0, 10'h180, 0, rd, cyc);
            chk(rd == 32'hBEEF0002, "R9", "load sees buffered store", rd, 32'hBEEF0002);
        end

        // full FIFO stalls stores
        idle(20);
        hold_ready = 1;
        idle(2);
        for (int k = 0; k < WB_DEPTH; k++) begin
            access(1, AW'(10'h040 + 4 * k), 32'h5100_0000 + k, rd, cyc);
            chk(cyc == 1, "R8", "store accepted while room", cyc, 1);
        end
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = 10'h04C; cpu_wdata = 32'h5100_00FF;
        r0 = 0;
        for (int k = 0; k < 4; k++) begin
            #1; if (cpu_stall) r0++;
            @(negedge clk);
        end
        chk(r0 == 4, "R8", "store stalled while FIFO full", r0, 4);
        hold_ready = 0;
        forever begin #1; if (!cpu_stall) break; @(negedge clk); end
        @(posedge clk); #1; cpu_req = 0;
        ref_mem[10'h04C >> 2] = 32'h5100_00FF;
        access(0, 10'h04C, 0, rd, cyc);
        chk(rd == 32'h5100_00FF, "R8", "stalled store not lost", rd, 32'h5100_00FF);

        // read behind queued store to same block
        if (!WA) begin
            idle(20);
            hold_ready = 1;
            idle(2);
            access(1, 10'h2C0, 32'hA11C_E003, rd, cyc);
            r0 = rd_reqs;
            @(negedge clk);
            cpu_req = 1; cpu_we = 0; cpu_addr = 10'h2C0;
            idle(5);
            chk(rd_reqs == r0 && cpu_stall, "R9", "no read while store queued", rd_reqs, r0);
            hold_ready = 0;
            forever begin #1; if (!cpu_stall) break; @(negedge clk); end
            rd = cpu_rdata;
            @(posedge clk); #1; cpu_req = 0;
            chk(rd == 32'hA11C_E003, "R9", "fill after drain has store", rd, 32'hA11C_E003);
        end

        // ordering of two stores to one word
        access(1, 10'h300, 32'h0000_1111, rd, cyc);
        access(1, 10'h300, 32'h0000_2222, rd, cyc);
        idle(30);
        chk(mem_val(10'h300 >> 2) == 32'h0000_2222, "R4", "later store wins in memory",
            mem_val(10'h300 >> 2), 32'h0000_2222);

        // random mix
        for (int n = 0; n < 400; n++) begin
            a = AW'((($urandom % 4) << 8) | (($urandom % 4) << 4) | (($urandom % 4) << 2));
            if ($urandom % 3 == 0) access(1, a, $urandom, rd, cyc);
            else begin
                access(0, a, 0, rd, cyc);
                chk(rd == ref_mem[a[AW-1:2]], "R3", "random load data", rd, ref_mem[a[AW-1:2]]);
            end
        end
        idle(60);
        r0 = 0;
        for (int i = 0; i < NWORDS; i++) if (mem_val(i) != ref_mem[i]) r0++;
        chk(r0 == 0, "R4", "memory image mismatches", r0, 0);
        done = 1;
    end
endmodule

module wt_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    bit timeout;

    wt_cache_tb_core #(.WA(1'b1), .CLK_PERIOD(CLK_PERIOD), .SEED(11)) core_alloc_i ();
    wt_cache_tb_core #(.WA(1'b0), .CLK_PERIOD(CLK_PERIOD), .SEED(23)) core_noalloc_i ();

    initial begin
        int n_chk, n_fail;
        timeout = 0;
        fork
            begin wait (core_alloc_i.done && core_noalloc_i.done); end
            begin #(CLK_PERIOD * 150000); timeout = 1; end
        join_any
        n_chk  = core_alloc_i.checks + core_noalloc_i.checks;
        n_fail = core_alloc_i.fails + core_noalloc_i.fails;
        if (timeout) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog: actual=timeout expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule